// File: doc/BRIEF.md
# Flash Erase Command Controller

This block is the erase side of the command interface of a parallel NOR flash device. It watches single-cycle bus writes (write strobe, address, data) and decodes the six-write unlock sequences that start either a whole-device erase or a sector erase. A sector erase opens an acceptance window. Inside the window, further sector erase writes add sectors to a one-bit-per-sector buffer, in any order, and each one restarts the window. When the window expires, an internal sequencer walks the buffer. For every selected sector it programs each word to zero, reads it back to confirm the zero, and then writes every word to all ones.

While the window is open or erase is running, reads return a status byte instead of array data. That byte carries a bit that flips on every read and a bit that shows the window has closed. A small behavioural array of `NUM_SECT * WPS` words stands in for the cells, so that the effect of each erase can be seen through ordinary reads.

Top module: `flash_erase_ctl`

## Requirements
- R1: Only these exact write sequences start an erase. Both begin with 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555 and 0x55 at 0x2AA. The sixth write is 0x10 at 0x555 for a whole-device erase, or 0x30 at any address for a sector erase of the sector in that address. Only the low 12 address bits are compared for the unlock writes. A write that does not match the next expected step returns the decoder to idle, and busy stays low.
- R2: A whole-device erase leaves every word of every sector reading 0xFF.
- R3: While the acceptance window is open, a write of 0x30 adds the sector in address bits [15:12] to the buffer and restarts the window.
- R4: The window closes exactly `WIN_CYC` clock cycles after the last write that opened or restarted it. `win_closed` is low while the window is open and goes high in that cycle.
- R5: Inside the window, any write whose data is not 0x30 or 0xB0 empties the buffer and returns to read mode on the next cycle. No word changes.
- R6: A sector erase sets every word of each queued sector to 0xFF and leaves all other words unchanged. Word n of the array (n = sector*WPS + address[1:0], n < 64) holds 0x40+n after reset.
- R7: While erase runs, writes are ignored. During a whole-device erase even 0xB0 is ignored. During a sector erase only 0xB0 is acted on.
- R8: When erase finishes, `busy` and `win_closed` drop, and reads return array data again.
- R9: While `busy` is high, a read returns a status byte. Bit 6 inverts on each read, bit 3 equals `win_closed`, and all other bits are zero.
- R10: A 0xB0 write during the window or during a sector erase halts the block. `busy` drops, `win_closed` stays high, array reads work, and no further word changes and no command is accepted until reset.
- R11: An active-low reset ends any erase at once. It clears `busy` and `win_closed` and restores the array to its reset contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | DATA_W | Bus write data |
| rd | input | 1 | Read strobe; advances the toggle bit while busy |
| rdata | output | DATA_W | Array word or status byte |
| busy | output | 1 | High while the window is open or erase runs |
| win_closed | output | 1 | High once the acceptance window has ended |

## Verification
A decoder that is stuck in a wrong unlock state shows up on the next write: `busy` rises when it should not, or fails to rise after a correct sixth write. A buffer that holds a wrong bit only shows up once erase completes, as a word reading 0xFF that should not, or the reverse. For that reason every erase is followed by a read of the whole array. A window counter that is off by one moves the rise of `win_closed` by one cycle, so that edge is sampled in the exact cycle it is due.

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_SECT = 16,
  parameter int WPS      = 4,
  parameter int WIN_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              win_closed
);
  localparam int SB = $clog2(NUM_SECT);
  localparam int WB = $clog2(WPS);
  localparam int NW = NUM_SECT * WPS;
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [11:0] A_ONE = 12'h555;
  localparam logic [11:0] A_TWO = 12'h2AA;
  localparam logic [DATA_W-1:0] D_AA   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_55   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_SET  = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] D_CHIP = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] D_SECT = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] D_SUSP = DATA_W'(8'hB0);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_SET, S_U4, S_U5, S_WIN, S_ERASE, S_SUSP
  } st_t;

  st_t                st;
  logic [NUM_SECT-1:0] sel;
  logic               chip;
  logic [CW-1:0]      cnt;
  logic [SB-1:0]      sidx;
  logic [WB-1:0]      widx;
  logic [1:0]         ph;
  logic               tog;
  logic [DATA_W-1:0]  mem [NW];

  wire at_one   = addr[11:0] == A_ONE;
  wire at_two   = addr[11:0] == A_TWO;
  wire unl_a    = at_one && wdata == D_AA;
  wire unl_b    = at_two && wdata == D_55;
  wire cmd_sect = wdata == D_SECT;
  wire cmd_susp = wdata == D_SUSP;
  wire [SB-1:0] wsect = addr[ADDR_W-1 -: SB];
  wire [SB+WB-1:0] ridx = {wsect, addr[WB-1:0]};
  wire [SB+WB-1:0] eidx = {sidx, widx};
  wire cur_sel  = sel[sidx];
  wire last_w   = widx == WB'(WPS - 1);
  wire sect_adv = !cur_sel || (ph == 2'd2 && last_w);
  wire susp_req = we && cmd_susp && !chip;
  wire done     = st == S_ERASE && !susp_req && sect_adv && sidx == SB'(NUM_SECT - 1);
  wire erasing  = st == S_ERASE && !susp_req && cur_sel;

  assign busy       = st == S_WIN || st == S_ERASE;
  assign win_closed = st == S_ERASE || st == S_SUSP;
  assign rdata      = busy ? DATA_W'({1'b0, tog, 2'b00, win_closed, 3'b000}) : mem[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; chip <= 1'b0; cnt <= '0;
      sidx <= '0; widx <= '0; ph <= 2'd0; tog <= 1'b0;
    end else begin
      if (rd && busy) tog <= ~tog;
      case (st)
        S_IDLE: if (we) st <= unl_a ? S_U1 : S_IDLE;
        S_U1:   if (we) st <= unl_b ? S_U2 : S_IDLE;
        S_U2:   if (we) st <= (at_one && wdata == D_SET) ? S_SET : S_IDLE;
        S_SET:  if (we) st <= unl_a ? S_U4 : S_IDLE;
        S_U4:   if (we) st <= unl_b ? S_U5 : S_IDLE;
        S_U5: if (we) begin
          if (at_one && wdata == D_CHIP) begin
            st <= S_ERASE; sel <= '1; chip <= 1'b1;
            sidx <= '0; widx <= '0; ph <= 2'd0;
          end else if (cmd_sect) begin
            st <= S_WIN; sel <= '0; sel[wsect] <= 1'b1; cnt <= '0;
          end else st <= S_IDLE;
        end
        S_WIN: begin
          if (we) begin
            if (cmd_sect) begin
              sel[wsect] <= 1'b1; cnt <= '0;
            end else if (cmd_susp) st <= S_SUSP;
            else begin
              st <= S_IDLE; sel <= '0;
            end
          end else if (cnt == CW'(WIN_CYC - 1)) begin
            st <= S_ERASE; sidx <= '0; widx <= '0; ph <= 2'd0;
          end else cnt <= cnt + 1'b1;
        end
        S_ERASE: begin
          if (susp_req) st <= S_SUSP;
          else if (done) begin
            st <= S_IDLE; sel <= '0; chip <= 1'b0;
          end else if (sect_adv) begin
            sidx <= sidx + 1'b1; widx <= '0; ph <= 2'd0;
          end else begin
            case (ph)
              2'd0: begin
                widx <= last_w ? '0 : widx + 1'b1;
                if (last_w) ph <= 2'd1;
              end
              2'd1: if (mem[eidx] == '0) begin
                widx <= last_w ? '0 : widx + 1'b1;
                if (last_w) ph <= 2'd2;
              end
              default: widx <= widx + 1'b1;
            endcase
          end
        end
        S_SUSP: st <= S_SUSP;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= DATA_W'(64 + i);
    end else if (erasing) begin
      case (ph)
        2'd0:    mem[eidx] <= '0;
        2'd1:    if (mem[eidx] != '0) mem[eidx] <= '0;
        default: mem[eidx] <= '1;
      endcase
    end
  end

  p_retrig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && we && cmd_sect) |=> (st == S_WIN && cnt == '0 && sel[$past(wsect)]));
  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_closed) |-> $past(st == S_WIN || st == S_U5));
  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && we && !cmd_sect && !cmd_susp) |=> (st == S_IDLE && sel == '0));
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && !done && !susp_req) |=> (st == S_ERASE && $stable(sel)));
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !win_closed && sel == '0));
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd) |=> tog != $past(tog));
  p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && susp_req) |=> (st == S_SUSP && !busy && win_closed));
endmodule

// File: tb/flash_erase_ctl_test.sv
`timescale 1ns/1ps
module flash_erase_ctl_test;
  localparam int WIN = 40;
  localparam int NS  = 16;
  localparam int NW  = 64;

  logic clk = 0, rst_n = 0, we = 0, rd = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy, win_closed;
  int nchk = 0, nerr = 0;
  logic [7:0] exp_mem [NW];

  flash_erase_ctl #(.WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rd(rd), .rdata(rdata), .busy(busy), .win_closed(win_closed));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] sa(input int s);
    return 16'(s) << 12;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < NW; n++) exp_mem[n] = 8'(8'h40 + n);
  endtask

  task automatic model_erase(input int s);
    for (int w = 0; w < 4; w++) exp_mem[s*4+w] = 8'hFF;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdw(input logic [15:0] a, output logic [7:0] v);
    rd = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic prefix();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic seq_sector(input int s);
    prefix(); wr(sa(s), 8'h30);
  endtask

  task automatic seq_chip();
    prefix(); wr(16'h0555, 8'h10);
  endtask

  task automatic verify_all(input string req);
    logic [7:0] v;
    for (int n = 0; n < NW; n++) begin
      rdw(sa(n/4) | 16'(n%4), v);
      chk(v == exp_mem[n], req, v, exp_mem[n]);
    end
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy && !win_closed, req, {busy, win_closed}, 0);
  endtask

  task automatic status_pair(input string req, input bit wc);
    logic [7:0] v1, v2;
    rdw(16'h0000, v1); rdw(16'h0000, v2);
    chk((v1 ^ v2) == 8'h40, req, v1 ^ v2, 8'h40);
    chk((v2 & 8'hBF) == {4'b0, wc, 3'b0}, req, v2 & 8'hBF, {4'b0, wc, 3'b0});
  endtask

  task automatic do_reset();
    rst_n = 0; idle(2); rst_n = 1; idle(1); model_reset();
  endtask

  bit fin = 0;
  initial begin
    #(200000 * 5);
    if (!fin) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd42));
    model_reset();
    idle(3); rst_n = 1; idle(1);
    chk(!busy && !win_closed, "R11 reset state", {busy, win_closed}, 0);
    verify_all("R6 reset contents");

    // R1: broken sequences do nothing
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h54); wr(sa(3), 8'h30);
    chk(!busy, "R1 wrong data in prefix", busy, 0);
    wr(16'h0556, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h10);
    chk(!busy, "R1 wrong address in prefix", busy, 0);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h81);
    prefix(); wr(16'h0555, 8'h11);
    chk(!busy, "R1 wrong final code", busy, 0);
    verify_all("R1 array untouched");

    // R3/R4/R9/R7/R6/R8 directed sector erase
    seq_sector(5);
    chk(busy && !win_closed, "R3 window open", {busy, win_closed}, 2);
    status_pair("R9 status in window", 0);
    idle(WIN - 8);
    chk(busy && !win_closed, "R3 still open before add", {busy, win_closed}, 2);
    wr(sa(2), 8'h30);
    idle(WIN - 5);
    chk(busy && !win_closed, "R3 restart kept window open", {busy, win_closed}, 2);
    wr(sa(9), 8'h30);
    idle(WIN - 1);
    chk(!win_closed && busy, "R4 open one cycle before end", win_closed, 0);
    idle(1);
    chk(win_closed && busy, "R4 closes after WIN_CYC", win_closed, 1);
    seq_sector(12);
    seq_chip();
    chk(busy, "R7 writes ignored during sector erase", busy, 1);
    status_pair("R9 status while erasing", 1);
    wait_idle("R8 busy drops when done");
    model_erase(5); model_erase(2); model_erase(9);
    verify_all("R6 queued sectors only");

    // R5 abort inside window
    seq_sector(3); wr(sa(3), 8'h30); wr(16'h0000, 8'hF0);
    chk(!busy && !win_closed, "R5 abort to read mode", {busy, win_closed}, 0);
    idle(WIN + 5);
    chk(!busy, "R5 no erase after abort", busy, 0);
    verify_all("R5 nothing erased");

    // R10 suspend inside window
    seq_sector(7); wr(sa(7), 8'hB0);
    chk(!busy && win_closed, "R10 suspend in window", {busy, win_closed}, 1);
    seq_sector(8); idle(WIN + 20);
    chk(!busy && win_closed, "R10 commands ignored when halted", {busy, win_closed}, 1);
    verify_all("R10 no change after suspend");
    do_reset();
    chk(!busy && !win_closed, "R11 reset leaves halt", {busy, win_closed}, 0);

    // R10 suspend during erase, before sectors 14/15 are reached
    seq_sector(15); wr(sa(14), 8'h30);
    idle(WIN);
    chk(win_closed, "R4 closed before suspend", win_closed, 1);
    wr(sa(14), 8'hB0);
    chk(!busy && win_closed, "R10 suspend while erasing", {busy, win_closed}, 1);
    idle(200);
    verify_all("R10 halted sectors unchanged");
    do_reset();

    // R11 reset mid-erase
    seq_sector(0); idle(WIN); idle(3);
    chk(busy && win_closed, "R11 erasing before reset", {busy, win_closed}, 3);
    rst_n = 0; #1;
    chk(!busy && !win_closed, "R11 immediate stop", {busy, win_closed}, 0);
    idle(2); rst_n = 1; idle(1); model_reset();
    verify_all("R11 contents after reset");

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      int k = $urandom_range(1, 5);
      bit ab = ($urandom_range(0, 4) == 0);
      bit q [NS];
      int s;
      for (int i = 0; i < NS; i++) q[i] = 0;
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h56);
      chk(!busy, "R1 random noise", busy, 0);
      s = $urandom_range(0, NS - 1);
      seq_sector(s); q[s] = 1;
      for (int i = 1; i < k; i++) begin
        idle($urandom_range(0, WIN - 6));
        chk(busy && !win_closed, "R3 random window open", {busy, win_closed}, 2);
        s = $urandom_range(0, NS - 1);
        wr(sa(s), 8'h30); q[s] = 1;
      end
      if (ab) begin
        idle($urandom_range(0, 10));
        wr(sa(0), 8'h00);
        chk(!busy, "R5 random abort", busy, 0);
      end else begin
        idle(WIN);
        chk(win_closed, "R4 random close", win_closed, 1);
        wait_idle("R8 random done");
        for (int i = 0; i < NS; i++) if (q[i]) model_erase(i);
      end
      verify_all("R6 random contents");
    end

    // R2 whole-device erase, with ignored suspend
    seq_chip();
    chk(busy && win_closed, "R2 chip erase running", {busy, win_closed}, 3);
    wr(sa(1), 8'hB0);
    chk(busy, "R7 suspend ignored in chip erase", busy, 1);
    wait_idle("R8 chip erase done");
    for (int i = 0; i < NS; i++) model_erase(i);
    verify_all("R2 all ones");

    fin = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule